// File: doc/BRIEF.md
# Linear Address Masking Stage

This block is one registered pipeline stage that sits in front of a TLB. It takes 64-bit virtual addresses from loads, stores and atomic read-modify-write requests. It strips software metadata out of the upper pointer bits by sign-extending from a chosen bit. The TLB lookup and the alignment check downstream then see a cleaned, canonical-shaped address instead of the raw one.

Bit 63 of the incoming address decides which rule applies:
- **Supervisor pointers** (bit 63 = 1) are governed by a single supervisor enable. The extension point is bit 56 under 5-level paging and bit 47 under 4-level paging.
- **User pointers** (bit 63 = 0) are governed by two enables carried in the translation-root register. The 6-bit metadata mode (bit 62) takes priority over the 15-bit metadata mode (bit 61).

When no masking applies, the address passes through unchanged. It is then flagged as a fault if it is not canonical for the active paging width.

The stage also produces the page-walk root base, taken from the translation-root register through a physical-address field mask. This keeps the two user masking enables out of the root address. A constant capability word reports that the feature is present.

Top module: `lam_stage`

## Requirements
- R1: A request with address bit 63 = 1, `sup_en_i` = 1 and `five_level_i` = 1 leaves with bits 63:57 replaced by copies of bit 56.
- R2: A request with address bit 63 = 1, `sup_en_i` = 1 and `five_level_i` = 0 leaves with bits 63:48 replaced by copies of bit 47.
- R3: A request with address bit 63 = 0 and `cr3_i[62]` = 1 leaves with bits 63:57 replaced by copies of bit 56, whatever `cr3_i[61]` and `five_level_i` hold.
- R4: A request with address bit 63 = 0, `cr3_i[62]` = 0 and `cr3_i[61]` = 1 leaves with bits 63:48 replaced by copies of bit 47, whatever `five_level_i` holds.
- R5: In every other case the address leaves unchanged. The user enables have no effect on supervisor pointers, and `sup_en_i` has no effect on user pointers.
- R6: `rsp_masked_o` is 1 exactly when one of the extensions in R1 to R4 was applied.
- R7: `rsp_fault_o` is 1 exactly when no extension was applied and some bit above the active width point differs from that point. The point is bit 56 when `five_level_i` = 1 and bit 47 otherwise. `rsp_fault_o` is never 1 together with `rsp_masked_o`.
- R8: A request accepted on a clock edge (`req_valid_i` and `req_ready_o` both high) appears on the response outputs after that edge, with `rsp_valid_o` high.
- R9: While `rsp_valid_o` = 1 and `rsp_ready_i` = 0, the response outputs hold stable, `req_ready_o` is 0, and new request inputs have no effect.
- R10: `root_base_o` equals `cr3_i` masked to bits PA_HI:PA_LO, registered with one cycle of delay. Bits 62 and 61 therefore never reach it.
- R11: `cap_o` is the constant 32-bit capability word, with only bit 26 set.
- R12: After reset, `rsp_valid_o`, `rsp_addr_o`, `rsp_masked_o`, `rsp_fault_o` and `root_base_o` are all 0, and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Stage can accept a request |
| req_addr_i | input | 64 | Raw virtual address |
| five_level_i | input | 1 | 5-level paging active |
| sup_en_i | input | 1 | Supervisor pointer masking enable |
| cr3_i | input | 64 | Translation-root register; bit 62 is the 6-bit user mode, bit 61 the 15-bit user mode |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Consumer accepts response |
| rsp_addr_o | output | 64 | Cleaned address |
| rsp_masked_o | output | 1 | Sign extension was applied |
| rsp_fault_o | output | 1 | Unmasked address is non-canonical |
| root_base_o | output | 64 | Page-walk root base |
| cap_o | output | 32 | Capability word (bit 26 set) |

## Verification
The bench builds the stage with PA_HI = 45 instead of the default 51. An all-ones root register then shows that the field mask really is a parameter: bits 51:46 must be cleared along with the control bits.

With the address width fixed at 64, the sweep covers every combination of the four control bits against both pointer kinds and both width-point bit values. It uses four metadata patterns (zero, all ones, sign copy, alternating). This reaches every rule, the user-mode priority, both canonical widths and the fault/mask exclusion.

// File: rtl/lam_pkg.sv
package lam_pkg;
  localparam int VA_W       = 64;
  localparam int CAP_W      = 32;
  localparam int U57_BIT    = 62;  // cr3 user 6-bit metadata enable
  localparam int U48_BIT    = 61;  // cr3 user 15-bit metadata enable
  localparam int CAP_BIT    = 26;
  localparam int PT4_TOP    = 47;
  localparam int PT5_TOP    = 56;

  typedef enum logic [1:0] {
    EXT_NONE = 2'd0,
    EXT_AT47 = 2'd1,
    EXT_AT56 = 2'd2
  } ext_e;
endpackage

// File: rtl/lam_ext_sel.sv
module lam_ext_sel
  import lam_pkg::*;
(
  input  logic ptr_sup_i,
  input  logic five_level_i,
  input  logic sup_en_i,
  input  logic u57_i,
  input  logic u48_i,
  output ext_e ext_o
);
  always_comb begin
    ext_o = EXT_NONE;
    if (ptr_sup_i) begin
      if (sup_en_i) ext_o = five_level_i ? EXT_AT56 : EXT_AT47;
    end else if (u57_i) begin
      ext_o = EXT_AT56;  // 6-bit mode wins over 15-bit mode
    end else if (u48_i) begin
      ext_o = EXT_AT47;
    end
  end
endmodule

// File: rtl/lam_sext.sv
module lam_sext
  import lam_pkg::*;
#(
  parameter int W = VA_W
) (
  input  logic [W-1:0] addr_i,
  input  ext_e         ext_i,
  input  logic         five_level_i,
  output logic [W-1:0] addr_o,
  output logic         masked_o,
  output logic         fault_o
);
  int ext_pt;
  int chk_pt;

  always_comb begin
    ext_pt   = (ext_i == EXT_AT56) ? PT5_TOP : PT4_TOP;
    masked_o = (ext_i != EXT_NONE);
    addr_o   = addr_i;
    if (masked_o) begin
      for (int i = 0; i < W; i++) begin
        if (i > ext_pt) addr_o[i] = addr_i[ext_pt];
      end
    end
  end

  always_comb begin
    chk_pt  = five_level_i ? PT5_TOP : PT4_TOP;
    fault_o = 1'b0;
    if (!masked_o) begin
      for (int i = 0; i < W; i++) begin
        if (i > chk_pt && addr_i[i] != addr_i[chk_pt]) fault_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lam_root_mask.sv
module lam_root_mask #(
  parameter int W     = 64,
  parameter int PA_LO = 12,
  parameter int PA_HI = 51
) (
  input  logic [W-1:0] cr3_i,
  output logic [W-1:0] root_o
);
  localparam logic [W-1:0] HI_MASK = (PA_HI >= W - 1) ? '1 : ((W'(1) << (PA_HI + 1)) - W'(1));
  localparam logic [W-1:0] LO_MASK = (W'(1) << PA_LO) - W'(1);
  localparam logic [W-1:0] FIELD   = HI_MASK & ~LO_MASK;

  assign root_o = cr3_i & FIELD;
endmodule

// File: rtl/lam_stage.sv
module lam_stage
  import lam_pkg::*;
#(
  parameter int PA_LO = 12,
  parameter int PA_HI = 51
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_addr_i,
  input  logic             five_level_i,
  input  logic             sup_en_i,
  input  logic [VA_W-1:0]  cr3_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [VA_W-1:0]  rsp_addr_o,
  output logic             rsp_masked_o,
  output logic             rsp_fault_o,
  output logic [VA_W-1:0]  root_base_o,
  output logic [CAP_W-1:0] cap_o
);
  ext_e            ext;
  logic [VA_W-1:0] clean_addr;
  logic            clean_masked;
  logic            clean_fault;
  logic [VA_W-1:0] root_d;
  logic            accept;

  lam_ext_sel u_sel (
    .ptr_sup_i   (req_addr_i[VA_W-1]),
    .five_level_i(five_level_i),
    .sup_en_i    (sup_en_i),
    .u57_i       (cr3_i[U57_BIT]),
    .u48_i       (cr3_i[U48_BIT]),
    .ext_o       (ext)
  );

  lam_sext #(.W(VA_W)) u_sext (
    .addr_i      (req_addr_i),
    .ext_i       (ext),
    .five_level_i(five_level_i),
    .addr_o      (clean_addr),
    .masked_o    (clean_masked),
    .fault_o     (clean_fault)
  );

  lam_root_mask #(.W(VA_W), .PA_LO(PA_LO), .PA_HI(PA_HI)) u_root (
    .cr3_i (cr3_i),
    .root_o(root_d)
  );

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;
  assign cap_o       = CAP_W'(1) << CAP_BIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_addr_o   <= '0;
      rsp_masked_o <= 1'b0;
      rsp_fault_o  <= 1'b0;
    end else if (req_ready_o) begin
      rsp_valid_o <= req_valid_i;
      if (accept) begin
        rsp_addr_o   <= clean_addr;
        rsp_masked_o <= clean_masked;
        rsp_fault_o  <= clean_fault;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) root_base_o <= '0;
    else         root_base_o <= root_d;
  end
endmodule

// File: rtl/lam_stage_chk.sv
module lam_stage_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [63:0] req_addr_i,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [63:0] rsp_addr_o,
  input logic        rsp_masked_o,
  input logic        rsp_fault_o
);
  // R8: accepted request shows up next cycle
  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o);

  // R9: stalled response holds
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_addr_o)
      && $stable(rsp_masked_o) && $stable(rsp_fault_o));

  // R7: fault and mask never together
  a_r7_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_masked_o && rsp_fault_o));

  // R6: masked result has sign-copied top bits
  a_r6_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_masked_o |-> (rsp_addr_o[63:57] == {7{rsp_addr_o[56]}}));

  // R5: unmasked result equals the accepted raw address
  a_r5_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_masked_o || (rsp_addr_o == $past(req_addr_i)));
endmodule

bind lam_stage lam_stage_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_addr_o  (rsp_addr_o),
  .rsp_masked_o(rsp_masked_o),
  .rsp_fault_o (rsp_fault_o)
);

// File: tb/tb_lam_stage.sv
`timescale 1ns/1ps
module tb_lam_stage;
  localparam int PA_HI = 45;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        req_valid_i = 0;
  logic        req_ready_o;
  logic [63:0] req_addr_i = '0;
  logic        five_level_i = 0;
  logic        sup_en_i = 0;
  logic [63:0] cr3_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1;
  logic [63:0] rsp_addr_o;
  logic        rsp_masked_o;
  logic        rsp_fault_o;
  logic [63:0] root_base_o;
  logic [31:0] cap_o;

  int checks = 0;
  int errors = 0;

  lam_stage #(.PA_HI(PA_HI)) dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sext(input logic [63:0] a, input int pt);
    int sh = 63 - pt;
    return 64'($signed(a << sh) >>> sh);
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    #12;
    // R12 reset state
    chk("R12", {63'd0, rsp_valid_o}, 64'd0);
    chk("R12", rsp_addr_o, 64'd0);
    chk("R12", {62'd0, rsp_masked_o, rsp_fault_o}, 64'd0);
    chk("R12", root_base_o, 64'd0);
    chk("R12", {63'd0, req_ready_o}, 64'd1);
    chk("R11", {32'd0, cap_o}, 64'h0400_0000);
    @(negedge clk_i) rst_ni = 1;

    // R1..R7 sweep
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 2; s++) begin
        for (int b56 = 0; b56 < 2; b56++) begin
          for (int b47 = 0; b47 < 2; b47++) begin
            for (int p = 0; p < 4; p++) begin
              logic [63:0] a, e;
              logic m, f;
              int tp;
              string tag;
              a = 64'h0000_1234_5678_9abc;
              a[47] = b47[0];
              a[56] = b56[0];
              a[63] = s[0];
              case (p)
                0: begin a[55:48] = 8'h00; a[62:57] = 6'h00; end
                1: begin a[55:48] = 8'hff; a[62:57] = 6'h3f; end
                2: begin a[55:48] = {8{a[47]}}; a[62:57] = {6{a[56]}}; end
                default: begin a[55:48] = 8'h55; a[62:57] = 6'h2a; end
              endcase
              @(negedge clk_i);
              five_level_i = c[3];
              sup_en_i     = c[2];
              cr3_i        = 64'h0000_0000_0012_3000;
              cr3_i[62]    = c[1];
              cr3_i[61]    = c[0];
              req_addr_i   = a;
              req_valid_i  = 1;
              tp = -1;
              if (s == 1 && c[2]) begin
                tp = c[3] ? 56 : 47;
                tag = c[3] ? "R1" : "R2";
              end else if (s == 0 && c[1]) begin
                tp = 56; tag = "R3";
              end else if (s == 0 && c[0]) begin
                tp = 47; tag = "R4";
              end else tag = "R5";
              m = (tp >= 0);
              e = m ? sext(a, tp) : a;
              f = !m && (a != sext(a, c[3] ? 56 : 47));
              @(negedge clk_i);
              chk(tag, rsp_addr_o, e);
              chk("R6", {63'd0, rsp_masked_o}, {63'd0, m});
              chk("R7", {63'd0, rsp_fault_o}, {63'd0, f});
              chk("R8", {63'd0, rsp_valid_o}, 64'd1);
            end
          end
        end
      end
    end

    // R9 stall hold
    @(negedge clk_i);
    five_level_i = 0; sup_en_i = 0; cr3_i = '0; cr3_i[61] = 1;
    req_addr_i = 64'h7e00_8000_0000_1000; req_valid_i = 1;
    @(negedge clk_i);
    rsp_ready_i = 0;
    req_addr_i = 64'h0123_4567_89ab_cdef;
    cr3_i = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R9", rsp_addr_o, 64'hffff_8000_0000_1000);
      chk("R9", {62'd0, rsp_valid_o, req_ready_o}, 64'd2);
    end
    rsp_ready_i = 1;
    @(negedge clk_i);
    chk("R9", rsp_addr_o, 64'h0123_4567_89ab_cdef);
    chk("R9", {63'd0, rsp_fault_o}, 64'd1);
    req_valid_i = 0;
    @(negedge clk_i);
    chk("R8", {63'd0, rsp_valid_o}, 64'd0);

    // R10 root base
    cr3_i = '1;
    @(negedge clk_i);
    chk("R10", root_base_o, ((64'd1 << (PA_HI + 1)) - 1) & ~64'hfff);
    cr3_i = 64'h6000_0000_0abc_d123;
    @(negedge clk_i);
    chk("R10", root_base_o, 64'h0000_0000_0abc_d000);
    chk("R11", {32'd0, cap_o}, 64'h0400_0000);
    finish_run();
  end
endmodule